// File: doc/BRIEF.md
# I2C Write-Only Command Register Target

This block is a write-only I2C target that loads three small control registers. It watches a serial clock line and a serial data line that come straight from the pads, synchronises both to the system clock and detects START and STOP conditions on them. After a START, the first byte must carry the block's fixed 7-bit address with the write direction bit. When it matches, the block acknowledges and then treats every further byte as a self-contained command.

A command byte packs a 3-bit register selector into its upper bits and a 5-bit value into its lower bits. No register-address byte comes first, so one acknowledged byte is enough to change one register. The three 5-bit registers drive the block's parallel output. The block pulls SDA low only through an open-drain style enable. Read transfers and clock stretching are not supported.

Top module: `i2c_cmd_target`

## Requirements
- R1: While rst_ni is low and right after it rises, regs_o is all zero and sda_oe_o is low.
- R2: After a START, the address byte 0x9C (7-bit address 0x4E, then direction bit 0) is acknowledged: sda_oe_o is high for the whole high phase of the ninth SCL pulse.
- R3: An address byte that differs from 0x9C in any bit, including 0x9D (direction bit 1), is not acknowledged. Every byte after it is neither acknowledged nor applied until the next START.
- R4: In a command byte, bits [7:5] select a register and bits [4:0] give its new value. Selector 001 loads regs_o[4:0], 010 loads regs_o[9:5] and 011 loads regs_o[14:10]. The other registers keep their values.
- R5: A command byte whose selector is 000, 100, 101, 110 or 111 is acknowledged and leaves all of regs_o unchanged.
- R6: Any number of command bytes may follow one address byte within a transaction. Each byte is acknowledged and applied in order.
- R7: sda_oe_o changes only while SCL is low. It is released after the SCL falling edge that ends the acknowledge bit.
- R8: A repeated START in the middle of a byte discards the partial byte. The next byte is then checked as an address.
- R9: A STOP returns the block to idle from any state. SCL pulses that come after it without a new START are neither acknowledged nor applied.
- R10: A command byte takes effect on its eighth SCL rising edge. A STOP issued before the acknowledge clock still leaves the new value in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | 15 | Register 1 in [4:0], register 2 in [9:5], register 3 in [14:10] |

## Verification
Two functions can land in the same SCL high phase. The first is the register commit on the eighth rising edge of a command byte. The second is a STOP, found by watching SDA while SCL stays high. The bench provokes this by sending a command byte that ends in a 0 bit and then raising SDA before SCL falls. The check expects the new value to stay in the register and the acknowledge enable to stay low. A repeated START that breaks into a byte is also driven in the middle of a byte. The bench then checks that the partial byte has no effect and that the next byte is judged as an address.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_SKIP
  } state_e;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_s      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // conditions only count while SCL stays high across both samples
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned         ADDR_W = 7,
  parameter logic [ADDR_W-1:0]   ADDR   = 7'h4E,
  parameter int unsigned         SEL_W  = 3,
  parameter int unsigned         VAL_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [SEL_W-1:0] wr_sel_o,
  output logic [VAL_W-1:0] wr_val_o,
  output state_e           state_o
);
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q, byte_nxt;
  logic              in_ack_q, ack_q, oe_q;
  logic              data_rise, last_rise;

  assign byte_nxt  = {shreg_q[BYTE_W-2:0], sda_i};
  assign data_rise = scl_rise_i & ~in_ack_q & (cnt_q < ACK_SLOT);
  assign last_rise = data_rise & (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      in_ack_q <= 1'b0;
      ack_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_i || stop_i) begin
      state_q  <= start_i ? ST_ADDR : ST_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      ack_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else if (state_q == ST_ADDR || state_q == ST_CMD) begin
      if (data_rise) begin
        shreg_q <= byte_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (last_rise) begin
          if (state_q == ST_CMD || byte_nxt == {ADDR, 1'b0}) ack_q <= 1'b1;
          else begin
            state_q <= ST_SKIP;
            cnt_q   <= '0;
          end
        end
      end else if (scl_fall_i) begin
        if (in_ack_q) begin
          in_ack_q <= 1'b0;
          oe_q     <= 1'b0;
          ack_q    <= 1'b0;
          cnt_q    <= '0;
          state_q  <= ST_CMD;
        end else if (cnt_q == ACK_SLOT) begin
          in_ack_q <= 1'b1;
          oe_q     <= ack_q;
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign wr_en_o  = last_rise & (state_q == ST_CMD);
  assign wr_sel_o = byte_nxt[BYTE_W-1 -: SEL_W];
  assign wr_val_o = byte_nxt[VAL_W-1:0];
  assign state_o  = state_q;
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs #(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned VAL_W    = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [SEL_W-1:0]          wr_sel_i,
  input  logic [VAL_W-1:0]          wr_val_i,
  output logic [NUM_REGS*VAL_W-1:0] regs_o
);
  // selector 0 and anything above NUM_REGS hit no register
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [VAL_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(g + 1)) val_q <= wr_val_i;
    end
    assign regs_o[g*VAL_W +: VAL_W] = val_q;
  end
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] ADDR        = 7'h4E,
  parameter int unsigned       SEL_W       = 3,
  parameter int unsigned       VAL_W       = 5,
  parameter int unsigned       NUM_REGS    = 3,
  parameter int unsigned       SYNC_STAGES = 2,
  localparam int unsigned      REGS_W      = NUM_REGS * VAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [REGS_W-1:0] regs_o
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic [VAL_W-1:0] wr_val;
  state_e           fsm_state;

  i2c_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_byte_fsm #(
    .ADDR_W (ADDR_W),
    .ADDR   (ADDR),
    .SEL_W  (SEL_W),
    .VAL_W  (VAL_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_sel_o   (wr_sel),
    .wr_val_o   (wr_val),
    .state_o    (fsm_state)
  );

  i2c_cmd_regs #(
    .NUM_REGS (NUM_REGS),
    .SEL_W    (SEL_W),
    .VAL_W    (VAL_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_val_i (wr_val),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned REGS_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [REGS_W-1:0] regs_o,
  input logic              start_det,
  input state_e            fsm_state
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i) else $error("oe moved while SCL high"); // R7
  AST_REGS_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> scl_i) else $error("register moved while SCL low"); // R10
  AST_SKIP_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == ST_SKIP) |-> !sda_oe_o) else $error("ack while skipping"); // R3
  AST_IDLE_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == ST_IDLE) |-> !sda_oe_o) else $error("ack while idle"); // R9
  AST_START_TO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (fsm_state == ST_ADDR)) else $error("start not honoured"); // R8
endmodule

bind i2c_cmd_target i2c_cmd_target_chk #(.REGS_W(REGS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .regs_o    (regs_o),
  .start_det (start_det),
  .fsm_state (fsm_state)
);

// File: tb/i2c_cmd_target_test.sv
module i2c_cmd_target_test;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1;
  logic sda_oe, sda_bus;
  logic [14:0] regs;
  logic [14:0] exp_regs = '0;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  i2c_cmd_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_h = 1'b1; wq(); scl = 1'b1; wq();
    acked = ~sda_bus;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic apply_model(input logic [7:0] b);
    if (b[7:5] >= 3'd1 && b[7:5] <= 3'd3) exp_regs[(b[7:5]-1)*5 +: 5] = b[4:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ak;
    repeat (3) @(negedge clk);
    check(regs == 0 && sda_oe == 0, "R1", "in reset", {regs, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(regs == 0 && sda_oe == 0, "R1", "after reset", {regs, sda_oe}, 0);

    // basic transaction
    bus_start();
    send_byte(8'h9C, ak);
    check(ak == 1, "R2", "address ack", ak, 1);
    send_byte(8'h25, ak);
    apply_model(8'h25);
    check(ak == 1, "R4", "command ack", ak, 1);
    check(sda_oe == 0, "R7", "release after ack", sda_oe, 0);
    bus_stop();
    check(regs == exp_regs, "R4", "reg1 load", regs, exp_regs);

    // exhaustive command sweep in one transaction
    bus_start();
    send_byte(8'h9C, ak);
    check(ak == 1, "R2", "address ack sweep", ak, 1);
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 32; v++) begin
        logic [7:0] b;
        b = {3'(s), 5'(v)};
        send_byte(b, ak);
        apply_model(b);
        check(ak == 1, (s >= 1 && s <= 3) ? "R6" : "R5", "sweep ack", ak, 1);
        check(regs == exp_regs, (s >= 1 && s <= 3) ? "R4" : "R5", "sweep regs", regs, exp_regs);
        check(sda_oe == 0, "R7", "sweep release", sda_oe, 0);
      end
    end
    bus_stop();

    // wrong addresses, including the read bit
    for (int k = 0; k < 8; k++) begin
      bus_start();
      send_byte(8'h9C ^ 8'(1 << k), ak);
      check(ak == 0, "R3", "bad address nack", ak, 0);
      send_byte(8'h2A, ak);
      check(ak == 0, "R3", "skipped byte nack", ak, 0);
      check(regs == exp_regs, "R3", "skipped byte regs", regs, exp_regs);
      bus_stop();
    end

    // clocking after STOP with no START
    scl = 1'b0; wq();
    send_byte(8'h3F, ak);
    check(ak == 0, "R9", "post-stop nack", ak, 0);
    check(regs == exp_regs, "R9", "post-stop regs", regs, exp_regs);

    // repeated START inside a byte
    bus_start();
    send_byte(8'h9C, ak);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'h9C, ak);
    check(ak == 1, "R8", "address after restart", ak, 1);
    check(regs == exp_regs, "R8", "partial byte dropped", regs, exp_regs);
    send_byte(8'h4A, ak);
    apply_model(8'h4A);
    check(regs == exp_regs, "R8", "reg2 after restart", regs, exp_regs);
    send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'h3F, ak);
    check(ak == 0, "R8", "byte after restart is address", ak, 0);
    check(regs == exp_regs, "R8", "no write from address slot", regs, exp_regs);
    bus_stop();

    // STOP in the eighth bit's high phase
    bus_start();
    send_byte(8'h9C, ak);
    for (int i = 7; i >= 1; i--) send_bit(1'(8'h6E >> i));
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
    apply_model(8'h6E);
    check(regs == exp_regs, "R10", "commit before stop", regs, exp_regs);
    check(sda_oe == 0, "R10", "no ack after stop", sda_oe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule